// File: doc/BRIEF.md
# Run Control State Sequencer

This block follows the run-control life cycle of one readout unit in hardware. The unit starts out unpowered. A power-up attempt either brings it to a ready state or, when the attempt fails, leaves it unpowered. From ready it is configured, and it then alternates between a run in progress and the idle configured state. While a run is in progress, bunch trains open and close a nested in-train state. A power-down request returns the unit to the unpowered state from anywhere.

Control software issues requests as one-cycle strobes. A request is accepted when it is legal in the current state and is the only strobe in its cycle. Otherwise the state is left as it is and a one-cycle error pulse is raised. When a run starts, the run number and run type on the inputs are captured and held on the outputs until the next run start. By default they are cleared when the unit powers down.

Top module: `run_ctrl_seq`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first request, `state_o` is Dead, `err_o` is 0, and `run_num_o` and `run_type_o` are 0.
- R2: `state_o` encodes the states as Dead=0, Ready=1, Configured=2, Running=3, InTrain=4 and never shows any other value.
- R3: A power-up strobe in Dead goes to Ready when `pwr_ok_i` is 1. It stays in Dead with no error when `pwr_ok_i` is 0. A power-up strobe in any other state is illegal.
- R4: A configuration-start strobe is legal in Ready when no configuration is pending, and in Configured. It leaves the unit in Ready with a configuration pending. A configuration-end strobe is legal only in Ready with a configuration pending. It moves the unit to Configured and clears the pending mark.
- R5: A run-start strobe in Configured moves the unit to Running. On that same edge it captures `run_num_i` and `run_type_i` into `run_num_o` and `run_type_o`.
- R6: `run_num_o` and `run_type_o` change only on an accepted run start, or when they are cleared by R10.
- R7: A run-end strobe moves Running to Configured. It is illegal in InTrain and in every other state.
- R8: A train-start strobe moves Running to InTrain. A train-end strobe moves InTrain back to Running.
- R9: A power-down strobe moves any state other than Dead to Dead and drops any pending configuration. In Dead it is illegal.
- R10: With `CLEAR_ON_DEAD`=1 (the default), an accepted power-down clears `run_num_o` and `run_type_o` to 0 on the same edge.
- R11: An illegal request leaves the state and the run outputs unchanged. It raises `err_o` for exactly the one cycle after the edge at which the strobe was sampled.
- R12: Two or more request strobes in the same cycle are treated as one illegal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_up_i | input | 1 | Power-up request strobe |
| pwr_ok_i | input | 1 | Power-up result, 1 = success, sampled with `pwr_up_i` |
| pwr_down_i | input | 1 | Power-down request strobe |
| cfg_start_i | input | 1 | Configuration-start request strobe |
| cfg_end_i | input | 1 | Configuration-end request strobe |
| run_start_i | input | 1 | Run-start request strobe |
| run_end_i | input | 1 | Run-end request strobe |
| train_start_i | input | 1 | Bunch-train-start request strobe |
| train_end_i | input | 1 | Bunch-train-end request strobe |
| run_num_i | input | RUN_NUM_W | Run number offered with run start |
| run_type_i | input | RUN_TYPE_W | Run type offered with run start |
| state_o | output | 3 | Current state code |
| run_num_o | output | RUN_NUM_W | Captured run number |
| run_type_o | output | RUN_TYPE_W | Captured run type |
| err_o | output | 1 | One-cycle illegal-request pulse |

## Verification
Every result is registered once. A strobe sampled at one rising edge therefore shows its new state, its captured run fields and its error pulse right after that same edge, and the error pulse is gone one edge later. The bench drives each request on a falling edge and steps its behavioural model across the rising edge. It compares all four outputs on the following falling edge, so every compare falls in the one cycle where the response is due. Idle cycles are compared too, which shows that an error pulse lasts no longer than one cycle and that the held run fields stay put.

// File: rtl/run_ctrl_pkg.sv
`timescale 1ns/1ps
package run_ctrl_pkg;

   localparam int unsigned RC_NUM_REQ = 8;
   localparam int unsigned RC_IDX_W   = $clog2(RC_NUM_REQ);
   localparam int unsigned RC_ST_W    = 3;

   typedef enum logic [RC_ST_W-1:0] {
      ST_DEAD       = 3'd0,
      ST_READY      = 3'd1,
      ST_CONFIGURED = 3'd2,
      ST_RUNNING    = 3'd3,
      ST_IN_TRAIN   = 3'd4
   } rc_state_e;

   typedef enum logic [RC_IDX_W-1:0] {
      RQ_PWR_UP      = 3'd0,
      RQ_PWR_DOWN    = 3'd1,
      RQ_CFG_START   = 3'd2,
      RQ_CFG_END     = 3'd3,
      RQ_RUN_START   = 3'd4,
      RQ_RUN_END     = 3'd5,
      RQ_TRAIN_START = 3'd6,
      RQ_TRAIN_END   = 3'd7
   } rc_req_e;

   typedef struct packed {
      logic    single;
      logic    multi;
      rc_req_e which;
   } rc_req_t;

endpackage

// File: rtl/rc_req_decode.sv
`timescale 1ns/1ps
module rc_req_decode
   import run_ctrl_pkg::*;
#(
   parameter int unsigned NUM_REQ = RC_NUM_REQ
) (
   input  logic [NUM_REQ-1:0] strobe_i,
   output rc_req_t            req_o
);

   localparam int unsigned CNT_W = $clog2(NUM_REQ + 1);

   if (NUM_REQ != RC_NUM_REQ) begin : g_bad_num_req
      $error("rc_req_decode: NUM_REQ must equal the package request count");
   end

   logic [CNT_W-1:0]    hit_cnt;
   logic [RC_IDX_W-1:0] low_idx;

   always_comb begin
      hit_cnt = '0;
      low_idx = '0;
      for (int i = NUM_REQ - 1; i >= 0; i--) begin
         if (strobe_i[i]) begin
            hit_cnt = hit_cnt + CNT_W'(1);
            low_idx = RC_IDX_W'(i);
         end
      end
   end

   always_comb begin
      req_o.single = (hit_cnt == CNT_W'(1));
      req_o.multi  = (hit_cnt > CNT_W'(1));
      req_o.which  = rc_req_e'(low_idx);
   end

endmodule

// File: rtl/rc_state_core.sv
`timescale 1ns/1ps
module rc_state_core
   import run_ctrl_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  rc_req_t   req_i,
   input  logic      pwr_ok_i,
   output rc_state_e state_o,
   output logic      err_o,
   output logic      load_run_o,
   output logic      go_dead_o
);

   rc_state_e state_q, state_d;
   logic      pend_q, pend_d;
   logic      err_q, err_d;
   logic      legal;

   always_comb begin
      state_d    = state_q;
      pend_d     = pend_q;
      legal      = 1'b0;
      load_run_o = 1'b0;
      go_dead_o  = 1'b0;
      if (req_i.single) begin
         unique case (req_i.which)
            RQ_PWR_UP: begin
               if (state_q == ST_DEAD) begin
                  legal = 1'b1;
                  if (pwr_ok_i) state_d = ST_READY;
               end
            end
            RQ_PWR_DOWN: begin
               if (state_q != ST_DEAD) begin
                  legal     = 1'b1;
                  state_d   = ST_DEAD;
                  pend_d    = 1'b0;
                  go_dead_o = 1'b1;
               end
            end
            RQ_CFG_START: begin
               if ((state_q == ST_READY && !pend_q) || state_q == ST_CONFIGURED) begin
                  legal   = 1'b1;
                  state_d = ST_READY;
                  pend_d  = 1'b1;
               end
            end
            RQ_CFG_END: begin
               if (state_q == ST_READY && pend_q) begin
                  legal   = 1'b1;
                  state_d = ST_CONFIGURED;
                  pend_d  = 1'b0;
               end
            end
            RQ_RUN_START: begin
               if (state_q == ST_CONFIGURED) begin
                  legal      = 1'b1;
                  state_d    = ST_RUNNING;
                  load_run_o = 1'b1;
               end
            end
            RQ_RUN_END: begin
               if (state_q == ST_RUNNING) begin
                  legal   = 1'b1;
                  state_d = ST_CONFIGURED;
               end
            end
            RQ_TRAIN_START: begin
               if (state_q == ST_RUNNING) begin
                  legal   = 1'b1;
                  state_d = ST_IN_TRAIN;
               end
            end
            RQ_TRAIN_END: begin
               if (state_q == ST_IN_TRAIN) begin
                  legal   = 1'b1;
                  state_d = ST_RUNNING;
               end
            end
            default: legal = 1'b0;
         endcase
      end
      err_d = req_i.multi | (req_i.single & ~legal);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_DEAD;
         pend_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
         err_q   <= err_d;
      end
   end

   assign state_o = state_q;
   assign err_o   = err_q;

endmodule

// File: rtl/rc_run_info.sv
`timescale 1ns/1ps
module rc_run_info #(
   parameter int unsigned NUM_W         = 32,
   parameter int unsigned TYPE_W        = 8,
   parameter bit          CLEAR_ON_DEAD = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              clear_i,
   input  logic [NUM_W-1:0]  num_i,
   input  logic [TYPE_W-1:0] type_i,
   output logic [NUM_W-1:0]  num_o,
   output logic [TYPE_W-1:0] type_o
);

   logic clr_eff;

   if (CLEAR_ON_DEAD) begin : g_clear
      assign clr_eff = clear_i;
   end else begin : g_keep
      assign clr_eff = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         num_o  <= '0;
         type_o <= '0;
      end else if (load_i) begin
         num_o  <= num_i;
         type_o <= type_i;
      end else if (clr_eff) begin
         num_o  <= '0;
         type_o <= '0;
      end
   end

endmodule

// File: rtl/run_ctrl_seq.sv
`timescale 1ns/1ps
module run_ctrl_seq
   import run_ctrl_pkg::*;
#(
   parameter int unsigned RUN_NUM_W     = 32,
   parameter int unsigned RUN_TYPE_W    = 8,
   parameter bit          CLEAR_ON_DEAD = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  pwr_up_i,
   input  logic                  pwr_ok_i,
   input  logic                  pwr_down_i,
   input  logic                  cfg_start_i,
   input  logic                  cfg_end_i,
   input  logic                  run_start_i,
   input  logic                  run_end_i,
   input  logic                  train_start_i,
   input  logic                  train_end_i,
   input  logic [RUN_NUM_W-1:0]  run_num_i,
   input  logic [RUN_TYPE_W-1:0] run_type_i,
   output logic [RC_ST_W-1:0]    state_o,
   output logic [RUN_NUM_W-1:0]  run_num_o,
   output logic [RUN_TYPE_W-1:0] run_type_o,
   output logic                  err_o
);

   if (RUN_NUM_W < 1 || RUN_NUM_W > 64) begin : g_bad_num_w
      $error("run_ctrl_seq: RUN_NUM_W must be 1..64");
   end
   if (RUN_TYPE_W < 1 || RUN_TYPE_W > 32) begin : g_bad_type_w
      $error("run_ctrl_seq: RUN_TYPE_W must be 1..32");
   end

   logic [RC_NUM_REQ-1:0] strobes;
   rc_req_t               req;
   rc_state_e             state;
   logic                  load_run;
   logic                  go_dead;

   always_comb begin
      strobes                      = '0;
      strobes[RQ_PWR_UP]      = pwr_up_i;
      strobes[RQ_PWR_DOWN]    = pwr_down_i;
      strobes[RQ_CFG_START]   = cfg_start_i;
      strobes[RQ_CFG_END]     = cfg_end_i;
      strobes[RQ_RUN_START]   = run_start_i;
      strobes[RQ_RUN_END]     = run_end_i;
      strobes[RQ_TRAIN_START] = train_start_i;
      strobes[RQ_TRAIN_END]   = train_end_i;
   end

   rc_req_decode #(
      .NUM_REQ(RC_NUM_REQ)
   ) u_dec (
      .strobe_i(strobes),
      .req_o   (req)
   );

   rc_state_core u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req),
      .pwr_ok_i  (pwr_ok_i),
      .state_o   (state),
      .err_o     (err_o),
      .load_run_o(load_run),
      .go_dead_o (go_dead)
   );

   rc_run_info #(
      .NUM_W        (RUN_NUM_W),
      .TYPE_W       (RUN_TYPE_W),
      .CLEAR_ON_DEAD(CLEAR_ON_DEAD)
   ) u_info (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_run),
      .clear_i(go_dead),
      .num_i  (run_num_i),
      .type_i (run_type_i),
      .num_o  (run_num_o),
      .type_o (run_type_o)
   );

   assign state_o = state;

endmodule

// File: rtl/run_ctrl_seq_chk.sv
`timescale 1ns/1ps
module run_ctrl_seq_chk
   import run_ctrl_pkg::*;
#(
   parameter int unsigned RUN_NUM_W     = 32,
   parameter int unsigned RUN_TYPE_W    = 8,
   parameter bit          CLEAR_ON_DEAD = 1'b1
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  pwr_up_i,
   input logic                  pwr_down_i,
   input logic                  cfg_start_i,
   input logic                  cfg_end_i,
   input logic                  run_start_i,
   input logic                  run_end_i,
   input logic                  train_start_i,
   input logic                  train_end_i,
   input logic [RUN_NUM_W-1:0]  run_num_i,
   input logic [RUN_TYPE_W-1:0] run_type_i,
   input logic [RC_ST_W-1:0]    state_o,
   input logic [RUN_NUM_W-1:0]  run_num_o,
   input logic [RUN_TYPE_W-1:0] run_type_o,
   input logic                  err_o
);

   logic [RC_NUM_REQ-1:0] strb;
   assign strb = {train_end_i, train_start_i, run_end_i, run_start_i,
                  cfg_end_i, cfg_start_i, pwr_down_i, pwr_up_i};

   // R2: only the five defined codes appear
   assert_state_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_o <= 3'd4);

   // R11: an error pulse comes with an unchanged state
   assert_err_holds_state_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (state_o == $past(state_o)));

   // R12: several strobes together give an error
   assert_multi_err_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(strb) > 1) |=> err_o);

   // R7: run end inside a train is refused
   assert_end_in_train_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_end_i && $countones(strb) == 1 && state_o == 3'(ST_IN_TRAIN)) |=> err_o);

   // R9: power down from a live state reaches Dead
   assert_pwr_down_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_down_i && $countones(strb) == 1 && state_o != 3'(ST_DEAD))
      |=> (state_o == 3'(ST_DEAD)));

   // R5: accepted run start captures both fields
   assert_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_start_i && $countones(strb) == 1 && state_o == 3'(ST_CONFIGURED))
      |=> (run_num_o == $past(run_num_i) && run_type_o == $past(run_type_i)));

   // R6: run fields move only on capture or on entry to Dead
   assert_info_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(run_num_o) || !$stable(run_type_o))
      |-> (state_o == 3'(ST_RUNNING) || state_o == 3'(ST_DEAD)));

endmodule

bind run_ctrl_seq run_ctrl_seq_chk #(
   .RUN_NUM_W    (RUN_NUM_W),
   .RUN_TYPE_W   (RUN_TYPE_W),
   .CLEAR_ON_DEAD(CLEAR_ON_DEAD)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .pwr_up_i     (pwr_up_i),
   .pwr_down_i   (pwr_down_i),
   .cfg_start_i  (cfg_start_i),
   .cfg_end_i    (cfg_end_i),
   .run_start_i  (run_start_i),
   .run_end_i    (run_end_i),
   .train_start_i(train_start_i),
   .train_end_i  (train_end_i),
   .run_num_i    (run_num_i),
   .run_type_i   (run_type_i),
   .state_o      (state_o),
   .run_num_o    (run_num_o),
   .run_type_o   (run_type_o),
   .err_o        (err_o)
);

// File: tb/run_ctrl_seq_tb_top.sv
`timescale 1ns/1ps
module run_ctrl_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  strb = '0;
   logic        pwr_ok = 1'b0;
   logic [31:0] rnum = '0;
   logic [7:0]  rtype = '0;
   logic [2:0]  state;
   logic [31:0] num_out;
   logic [7:0]  type_out;
   logic        err;

   int vectors = 0;
   int fails   = 0;
   int cycles  = 0;

   // behavioural reference
   int          m_state = 0;
   bit          m_pend  = 0;
   bit          m_err   = 0;
   logic [31:0] m_num   = '0;
   logic [7:0]  m_type  = '0;

   always #2 clk = ~clk;

   run_ctrl_seq dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .pwr_up_i     (strb[0]),
      .pwr_ok_i     (pwr_ok),
      .pwr_down_i   (strb[1]),
      .cfg_start_i  (strb[2]),
      .cfg_end_i    (strb[3]),
      .run_start_i  (strb[4]),
      .run_end_i    (strb[5]),
      .train_start_i(strb[6]),
      .train_end_i  (strb[7]),
      .run_num_i    (rnum),
      .run_type_i   (rtype),
      .state_o      (state),
      .run_num_o    (num_out),
      .run_type_o   (type_out),
      .err_o        (err)
   );

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         fails++;
         $display("FAIL R11 watchdog: actual %0d cycles, expected completion", cycles);
         summary();
         $finish;
      end
   end

   // strobe bits: 0 pwr_up,1 pwr_down,2 cfg_start,3 cfg_end,4 run_start,5 run_end,6 train_start,7 train_end
   task automatic model(input logic [7:0] m, input bit ok, input logic [31:0] n, input logic [7:0] t);
      bit legal = 0;
      int nst = m_state;
      if ($countones(m) == 0) begin
         m_err = 0;
         return;
      end
      if ($countones(m) > 1) begin
         m_err = 1;
         return;
      end
      if (m[0] && m_state == 0) begin legal = 1; if (ok) nst = 1; end
      if (m[1] && m_state != 0) begin
         legal = 1; nst = 0; m_pend = 0; m_num = '0; m_type = '0;
      end
      if (m[2] && ((m_state == 1 && !m_pend) || m_state == 2)) begin legal = 1; nst = 1; m_pend = 1; end
      if (m[3] && m_state == 1 && m_pend) begin legal = 1; nst = 2; m_pend = 0; end
      if (m[4] && m_state == 2) begin legal = 1; nst = 3; m_num = n; m_type = t; end
      if (m[5] && m_state == 3) begin legal = 1; nst = 2; end
      if (m[6] && m_state == 3) begin legal = 1; nst = 4; end
      if (m[7] && m_state == 4) begin legal = 1; nst = 3; end
      m_state = nst;
      m_err   = !legal;
   endtask

   task automatic compare(input string tag);
      vectors++;
      if (state !== 3'(m_state)) begin
         fails++; $display("FAIL %s state: actual %0d expected %0d", tag, state, m_state);
      end
      if (err !== m_err) begin
         fails++; $display("FAIL %s err: actual %0b expected %0b", tag, err, m_err);
      end
      if (num_out !== m_num) begin
         fails++; $display("FAIL %s run_num: actual %h expected %h", tag, num_out, m_num);
      end
      if (type_out !== m_type) begin
         fails++; $display("FAIL %s run_type: actual %h expected %h", tag, type_out, m_type);
      end
   endtask

   // called at a falling edge; compares at the next falling edge
   task automatic step(input logic [7:0] m, input bit ok, input logic [31:0] n,
                       input logic [7:0] t, input string tag);
      strb = m; pwr_ok = ok; rnum = n; rtype = t;
      model(m, ok, n, t);
      @(posedge clk);
      @(negedge clk);
      strb = '0;
      compare(tag);
   endtask

   task automatic idle(input string tag);
      step(8'h00, 1'b0, 32'hFFFF_FFFF, 8'hFF, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");            // inside reset
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");            // after release
      step(8'h01, 1'b0, '0, '0, "R3");             // power-up fails, stays Dead
      step(8'h04, 1'b0, '0, '0, "R3");             // cfg_start in Dead -> error
      step(8'h01, 1'b1, '0, '0, "R3");             // power-up succeeds
      step(8'h01, 1'b1, '0, '0, "R3");             // power-up in Ready illegal
      step(8'h08, 1'b0, '0, '0, "R4");             // cfg_end without start
      step(8'h04, 1'b0, '0, '0, "R4");
      step(8'h04, 1'b0, '0, '0, "R4");             // second start refused
      step(8'h08, 1'b0, '0, '0, "R4");             // -> Configured
      step(8'h40, 1'b0, '0, '0, "R11");            // train_start in Configured
      idle("R11");
      step(8'h10, 1'b0, 32'h1234_5678, 8'h5A, "R5");
      step(8'h10, 1'b0, 32'hDEAD_BEEF, 8'h77, "R6"); // second start refused, fields held
      step(8'h40, 1'b0, 32'h0BAD_F00D, 8'h11, "R8");
      step(8'h20, 1'b0, '0, '0, "R7");             // run end in train refused
      step(8'h80, 1'b0, '0, '0, "R8");
      step(8'h20, 1'b0, '0, '0, "R7");             // -> Configured
      step(8'h30, 1'b0, 32'h5555_AAAA, 8'h33, "R12"); // two strobes
      step(8'h03, 1'b1, '0, '0, "R12");
      idle("R12");
      step(8'h04, 1'b0, '0, '0, "R4");             // reconfigure from Configured
      step(8'h08, 1'b0, '0, '0, "R4");
      step(8'h10, 1'b0, 32'hCAFE_0001, 8'h02, "R5");
      step(8'h40, 1'b0, '0, '0, "R8");
      step(8'h02, 1'b0, '0, '0, "R9");             // power down from InTrain
      step(8'h02, 1'b0, '0, '0, "R9");             // power down in Dead illegal
      idle("R10");
      for (int i = 0; i < 400; i++) begin
         logic [7:0] m;
         int sel = $urandom_range(0, 11);
         if (sel < 8)       m = 8'(1 << sel);
         else if (sel < 10) m = 8'($urandom) | 8'h03;
         else               m = 8'h00;
         step(m, 1'($urandom), $urandom, 8'($urandom), "R11");
      end
      summary();
      $finish;
   end

endmodule